// File: doc/BRIEF.md
# Edge-Triggered Event Capture Unit

The unit watches a bus of up to 32 trigger source signals and records an event when a software-chosen source shows a chosen edge. Each recorded event holds the value of a free-running 32-bit timestamp counter and a snapshot of the whole source bus. The trigger can be qualified in two ways. A deglitch filter can be applied to the selected trigger line, so that a new level only counts after it has been held for a programmable number of clocks. A pre-condition, drawn from the same source bus, can also be required. It is either a level that must hold or an edge that must have been seen since the last capture.

Two capture styles are available. In single-shot style, one arm command allows exactly one capture, which lands in a capture register. In auto-arm style, the unit stays armed and pushes every accepted event into a small FIFO for software to drain. When the FIFO is full, further events are dropped and a sticky overflow flag is set.

Software uses a simple register port to set up and observe the block. The port has an address, a write strobe, write data and a combinational read-data output.

Top module: `evtCapture`

## Requirements
- R1: After reset the control register, status register, capture timestamp and capture snapshot all read 0.
- R2: The control register (address 0) stores bits 20:0 and reads them back unchanged, and bits 31:21 read 0. The fields are: trigger source in bits 4:0, edge code in bits 6:5, filter enable in bit 7, filter length in bits 11:8, pre-condition source in bits 16:12, pre-condition kind in bits 19:17, and auto-arm in bit 20. The command register (address 1) always reads 0.
- R3: The trigger is the source bit chosen by the trigger-source field. The edge codes are 1 for rising, 2 for falling and 3 for either edge. Under code 0 no edge is ever accepted.
- R4: A write with bit 0 set to address 1 arms the unit and clears the triggered flag. Status (address 2) shows armed in bit 0 and triggered in bit 1. In single-shot style, the first accepted event clears armed and sets triggered. Later edges leave the capture registers unchanged until the unit is armed again.
- R5: The timestamp counter advances by one every clock. An event is recorded a fixed two clocks after the source changes, so two recorded timestamps differ by exactly the number of clocks between their source changes. The snapshot is the source bus as it stands on the capture clock. Single-shot results read at address 3 (timestamp) and address 4 (snapshot).
- R6: With the filter enabled and length N (0 behaves as 1), the selected trigger line must hold a new level for N consecutive clocks before an edge is seen. A shorter pulse is ignored.
- R7: Pre-condition kind 1 accepts a trigger only while the pre-condition source is high, and kind 2 only while it is low. Kind 0 always accepts.
- R8: Pre-condition kinds 3, 4 and 5 (rising, falling, either edge) are latched when the edge occurs. The latch is cleared by an arm command and by every accepted event, so each further trigger needs a fresh pre-condition edge.
- R9: In auto-arm style, every accepted event is pushed into the FIFO and the unit stays armed. The FIFO fill count shows in status bits 15:8. The oldest entry reads at address 5 (timestamp) and address 6 (snapshot). A write with bit 2 set to address 1 removes the oldest entry.
- R10: An event that arrives while the FIFO is full is dropped and sets the sticky overflow flag in status bit 2. The flag clears only when 1 is written to status bit 2; writing 0 leaves it set.
- R11: A write with bit 1 set to address 1 disarms the unit, after which trigger edges are not recorded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcIn | input | NUM_SRC | Trigger source bus, already synchronous to clk |
| regAddr | input | 4 | Register address for reads and writes |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Combinational read data for regAddr |

## Verification
The bench builds the unit with all 32 sources, so the highest trigger index (31) and the widest snapshot are exercised. The FIFO depth is set to 4, which lets six quick toggles fill the buffer, drop two events and raise overflow within a few dozen clocks. That same depth also makes the draining order and the spacing of the stored timestamps easy to check. The filter length of 4 puts both a rejected 2-clock pulse and the exact acceptance clock inside one short window.

// File: rtl/evtCapPkg.sv
package evtCapPkg;

  localparam int MAX_SRC = 32;
  localparam int SEL_W   = $clog2(MAX_SRC);
  localparam int FILT_W  = 4;
  localparam int TS_W    = 32;
  localparam int ADDR_W  = 4;
  localparam int DATA_W  = 32;
  localparam int CTRL_W  = 21;

  localparam logic [ADDR_W-1:0] ADR_CTRL    = 4'd0;
  localparam logic [ADDR_W-1:0] ADR_CMD     = 4'd1;
  localparam logic [ADDR_W-1:0] ADR_STATUS  = 4'd2;
  localparam logic [ADDR_W-1:0] ADR_CAP_TS  = 4'd3;
  localparam logic [ADDR_W-1:0] ADR_CAP_SNP = 4'd4;
  localparam logic [ADDR_W-1:0] ADR_BUF_TS  = 4'd5;
  localparam logic [ADDR_W-1:0] ADR_BUF_SNP = 4'd6;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_ANY  = 2'd3
  } trigEdge_e;

  typedef enum logic [2:0] {
    PRE_NONE = 3'd0,
    PRE_HIGH = 3'd1,
    PRE_LOW  = 3'd2,
    PRE_RISE = 3'd3,
    PRE_FALL = 3'd4,
    PRE_ANY  = 3'd5,
    PRE_RSV6 = 3'd6,
    PRE_RSV7 = 3'd7
  } preKind_e;

  // packed MSB first: autoArm is bit 20, trigSel occupies bits 4:0
  typedef struct packed {
    logic             autoArm;
    preKind_e         preKind;
    logic [SEL_W-1:0] preSel;
    logic [FILT_W-1:0] filtLen;
    logic             filtEn;
    trigEdge_e        trigEdge;
    logic [SEL_W-1:0] trigSel;
  } capCfg_t;

  typedef struct packed {
    logic armNow;
    logic clrPre;
    logic capSingle;
    logic pushBuf;
    logic popBuf;
    logic clrOvf;
  } capStrb_t;

endpackage

// File: rtl/evtCapFilter.sv
module evtCapFilter #(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LEN_W-1:0] holdLen,
  input  logic             rawIn,
  output logic             cleanOut
);

  logic [LEN_W-1:0] runCnt;
  logic [LEN_W:0]   runNext;
  logic [LEN_W:0]   needed;

  assign runNext = {1'b0, runCnt} + 1'b1;
  assign needed  = (holdLen == '0) ? {{LEN_W{1'b0}}, 1'b1} : {1'b0, holdLen};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cleanOut <= 1'b0;
      runCnt   <= '0;
    end else if (rawIn != cleanOut) begin
      if (runNext >= needed) begin
        cleanOut <= rawIn;
        runCnt   <= '0;
      end else begin
        runCnt <= runNext[LEN_W-1:0];
      end
    end else begin
      runCnt <= '0;
    end
  end

endmodule

// File: rtl/evtCapFifo.sv
module evtCapFifo #(
  parameter int WIDTH = 64,
  parameter int DEPTH = 4,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] headData,
  output logic [CNT_W-1:0] fill,
  output logic             full
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [AW-1:0]    LAST_IDX = AW'(DEPTH - 1);

  logic [WIDTH-1:0] store [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic             doPush, doPop;

  assign full     = (fill == FULL_CNT);
  assign doPush   = push && !full;
  assign doPop    = pop && (fill != '0);
  assign headData = store[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) store[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      fill  <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == LAST_IDX) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == LAST_IDX) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

endmodule

// File: rtl/evtCapDatapath.sv
module evtCapDatapath
  import evtCapPkg::*;
#(
  parameter int NUM_SRC    = 32,
  parameter int FIFO_DEPTH = 4,
  parameter int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  capCfg_t            cfg,
  input  capStrb_t           strb,
  output logic               trigFire,
  output logic [TS_W-1:0]    tsNow,
  output logic [TS_W-1:0]    capTs,
  output logic [MAX_SRC-1:0] capSnap,
  output logic [TS_W-1:0]    bufTs,
  output logic [MAX_SRC-1:0] bufSnap,
  output logic [CNT_W-1:0]   bufFill,
  output logic               bufFull
);

  localparam int ENTRY_W = TS_W + MAX_SRC;

  logic [MAX_SRC-1:0] srcWide;
  logic rawTrig, rawTrigQ, filtTrig, trigLvl, trigPrev;
  logic preQ, prePrev, preRise, preFall, preEdgeHit, preSeen, preOk;
  logic trigHit;
  logic [ENTRY_W-1:0] bufHead;
  logic unusedDp;

  assign unusedDp = ^{strb.armNow, strb.clrOvf, cfg.autoArm};

  always_comb begin
    srcWide = '0;
    for (int i = 0; i < NUM_SRC; i++) srcWide[i] = srcIn[i];
  end

  assign rawTrig = srcWide[cfg.trigSel];

  evtCapFilter #(.LEN_W(FILT_W)) uFilt (
    .clk     (clk),
    .rstN    (rstN),
    .holdLen (cfg.filtLen),
    .rawIn   (rawTrig),
    .cleanOut(filtTrig)
  );

  assign trigLvl = cfg.filtEn ? filtTrig : rawTrigQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rawTrigQ <= 1'b0;
      trigPrev <= 1'b0;
      preQ     <= 1'b0;
      prePrev  <= 1'b0;
      preSeen  <= 1'b0;
      tsNow    <= '0;
    end else begin
      rawTrigQ <= rawTrig;
      trigPrev <= trigLvl;
      preQ     <= srcWide[cfg.preSel];
      prePrev  <= preQ;
      tsNow    <= tsNow + 1'b1;
      if (strb.clrPre)    preSeen <= 1'b0;
      else if (preEdgeHit) preSeen <= 1'b1;
    end
  end

  always_comb begin
    case (cfg.trigEdge)
      EDGE_RISE: trigHit = trigLvl && !trigPrev;
      EDGE_FALL: trigHit = !trigLvl && trigPrev;
      EDGE_ANY:  trigHit = trigLvl != trigPrev;
      default:   trigHit = 1'b0;
    endcase
  end

  assign preRise = preQ && !prePrev;
  assign preFall = !preQ && prePrev;

  always_comb begin
    case (cfg.preKind)
      PRE_RISE: preEdgeHit = preRise;
      PRE_FALL: preEdgeHit = preFall;
      PRE_ANY:  preEdgeHit = preRise || preFall;
      default:  preEdgeHit = 1'b0;
    endcase
    case (cfg.preKind)
      PRE_HIGH:                   preOk = preQ;
      PRE_LOW:                    preOk = !preQ;
      PRE_RISE, PRE_FALL, PRE_ANY: preOk = preSeen || preEdgeHit;
      default:                    preOk = 1'b1;
    endcase
  end

  assign trigFire = trigHit && preOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capTs   <= '0;
      capSnap <= '0;
    end else if (strb.capSingle) begin
      capTs   <= tsNow;
      capSnap <= srcWide;
    end
  end

  evtCapFifo #(.WIDTH(ENTRY_W), .DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) uBuf (
    .clk     (clk),
    .rstN    (rstN),
    .push    (strb.pushBuf),
    .pop     (strb.popBuf),
    .wrData  ({tsNow, srcWide}),
    .headData(bufHead),
    .fill    (bufFill),
    .full    (bufFull)
  );

  assign bufTs   = bufHead[ENTRY_W-1:MAX_SRC];
  assign bufSnap = bufHead[MAX_SRC-1:0];

endmodule

// File: rtl/evtCapControl.sv
module evtCapControl
  import evtCapPkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWrEn,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  input  logic               trigFire,
  input  logic               bufFull,
  input  logic [CNT_W-1:0]   bufFill,
  input  logic [TS_W-1:0]    capTs,
  input  logic [MAX_SRC-1:0] capSnap,
  input  logic [TS_W-1:0]    bufTs,
  input  logic [MAX_SRC-1:0] bufSnap,
  output capCfg_t            cfg,
  output capStrb_t           strb,
  output logic               armed,
  output logic               overflow
);

  logic triggered, accept, disarmNow, wrCtrl, wrCmd, wrStat;
  logic unusedWrBits;

  assign unusedWrBits = ^regWrData[DATA_W-1:CTRL_W];

  assign wrCtrl = regWrEn && (regAddr == ADR_CTRL);
  assign wrCmd  = regWrEn && (regAddr == ADR_CMD);
  assign wrStat = regWrEn && (regAddr == ADR_STATUS);

  assign accept    = armed && trigFire;
  assign disarmNow = wrCmd && regWrData[1];

  always_comb begin
    strb           = '0;
    strb.armNow    = wrCmd && regWrData[0];
    strb.popBuf    = wrCmd && regWrData[2];
    strb.clrOvf    = wrStat && regWrData[2];
    strb.capSingle = accept && !cfg.autoArm;
    strb.pushBuf   = accept && cfg.autoArm && !bufFull;
    strb.clrPre    = strb.armNow || accept;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg       <= '0;
      armed     <= 1'b0;
      triggered <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      if (wrCtrl) cfg <= capCfg_t'(regWrData[CTRL_W-1:0]);

      if (strb.armNow)        armed <= 1'b1;
      else if (disarmNow)     armed <= 1'b0;
      else if (strb.capSingle) armed <= 1'b0;

      if (strb.armNow)  triggered <= 1'b0;
      else if (accept)  triggered <= 1'b1;

      if (accept && cfg.autoArm && bufFull) overflow <= 1'b1;
      else if (strb.clrOvf)                 overflow <= 1'b0;
    end
  end

  always_comb begin
    case (regAddr)
      ADR_CTRL:    regRdData = DATA_W'(cfg);
      ADR_STATUS:  regRdData = {16'h0, 8'(bufFill), 5'b0, overflow, triggered, armed};
      ADR_CAP_TS:  regRdData = capTs;
      ADR_CAP_SNP: regRdData = capSnap;
      ADR_BUF_TS:  regRdData = bufTs;
      ADR_BUF_SNP: regRdData = bufSnap;
      default:     regRdData = '0;
    endcase
  end

endmodule

// File: rtl/evtCapture.sv
module evtCapture
  import evtCapPkg::*;
#(
  parameter int NUM_SRC    = 32,
  parameter int FIFO_DEPTH = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWrEn,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData
);

  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  capCfg_t            cfg;
  capStrb_t           strb;
  logic               trigFire, bufFull, armed, overflow;
  logic [CNT_W-1:0]   bufFill;
  logic [TS_W-1:0]    tsNow, capTs, bufTs;
  logic [MAX_SRC-1:0] capSnap, bufSnap;

  evtCapDatapath #(.NUM_SRC(NUM_SRC), .FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) uPath (
    .clk     (clk),
    .rstN    (rstN),
    .srcIn   (srcIn),
    .cfg     (cfg),
    .strb    (strb),
    .trigFire(trigFire),
    .tsNow   (tsNow),
    .capTs   (capTs),
    .capSnap (capSnap),
    .bufTs   (bufTs),
    .bufSnap (bufSnap),
    .bufFill (bufFill),
    .bufFull (bufFull)
  );

  evtCapControl #(.CNT_W(CNT_W)) uCtl (
    .clk      (clk),
    .rstN     (rstN),
    .regAddr  (regAddr),
    .regWrEn  (regWrEn),
    .regWrData(regWrData),
    .regRdData(regRdData),
    .trigFire (trigFire),
    .bufFull  (bufFull),
    .bufFill  (bufFill),
    .capTs    (capTs),
    .capSnap  (capSnap),
    .bufTs    (bufTs),
    .bufSnap  (bufSnap),
    .cfg      (cfg),
    .strb     (strb),
    .armed    (armed),
    .overflow (overflow)
  );

endmodule

// File: rtl/evtCapChecker.sv
module evtCapChecker
  import evtCapPkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int CNT_W      = 3
) (
  input logic             clk,
  input logic             rstN,
  input capStrb_t         strb,
  input logic             armed,
  input logic             overflow,
  input logic [CNT_W-1:0] bufFill,
  input logic [TS_W-1:0]  tsNow
);

  localparam logic [CNT_W-1:0] DEPTH_CNT = CNT_W'(FIFO_DEPTH);

  // R5
  ts_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> tsNow == $past(tsNow) + 1'b1);

  // R4
  single_disarm_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.capSingle && !strb.armNow |=> !armed);

  // R9
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    bufFill <= DEPTH_CNT);

  // R10
  push_room_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.pushBuf |-> bufFill < DEPTH_CNT);

  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    overflow && !strb.clrOvf |=> overflow);

  // R9
  one_sink_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.capSingle, strb.pushBuf}));

endmodule

bind evtCapture evtCapChecker #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .strb    (strb),
  .armed   (armed),
  .overflow(overflow),
  .bufFill (bufFill),
  .tsNow   (tsNow)
);

// File: tb/tb_evtCapture.sv
module tb_evtCapture;

  localparam int NUM_SRC    = 32;
  localparam int FIFO_DEPTH = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] srcIn = '0;
  logic [3:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;

  always #10 clk = ~clk;

  evtCapture #(.NUM_SRC(NUM_SRC), .FIFO_DEPTH(FIFO_DEPTH)) dut (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData)
  );

  int nChecks = 0;
  int nFails  = 0;

  typedef struct {
    logic [3:0]  addr;
    logic [31:0] exp;
    string       req;
  } expItem_t;

  expItem_t expQ[$];
  event     readEv;

  function automatic logic [31:0] mkCtrl(int tSel, int edgeCode, int fEn, int fLen,
                                         int pSel, int pKind, int auto);
    logic [31:0] v;
    v = 32'(tSel & 31) | (32'(edgeCode & 3) << 5) | (32'(fEn & 1) << 7) |
        (32'(fLen & 15) << 8) | (32'(pSel & 31) << 12) | (32'(pKind & 7) << 17) |
        (32'(auto & 1) << 20);
    return v;
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  // driver side of the scoreboard
  task automatic expectRd(logic [3:0] a, logic [31:0] e, string req);
    expItem_t it;
    it.addr = a; it.exp = e; it.req = req;
    regAddr = a;
    expQ.push_back(it);
    -> readEv;
    #2;
  endtask

  task automatic peek(logic [3:0] a, output logic [31:0] v);
    regAddr = a;
    #1;
    v = regRdData;
  endtask

  task automatic checkEq(logic [31:0] act, logic [31:0] e, string req);
    nChecks++;
    if (act !== e) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, e);
    end
  endtask

  // monitor side of the scoreboard
  initial begin
    forever begin
      @(readEv);
      #1;
      while (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        nChecks++;
        if (regRdData !== it.exp) begin
          nFails++;
          $display("FAIL %s: addr %0d actual %h expected %h", it.req, it.addr, regRdData, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [31:0] t1, tPrev, tCur;
    tick(3);
    rstN = 1'b1;
    tick(1);

    // R1 reset state
    expectRd(4'd2, 32'h0, "R1 status");
    expectRd(4'd0, 32'h0, "R1 ctrl");
    expectRd(4'd3, 32'h0, "R1 capTs");
    expectRd(4'd4, 32'h0, "R1 capSnap");

    // R2 readback
    wr(4'd0, 32'hFFFF_FFFF);
    expectRd(4'd0, 32'h001F_FFFF, "R2 all ones");
    wr(4'd0, 32'h0015_A3C5);
    expectRd(4'd0, 32'h0015_A3C5, "R2 pattern");
    expectRd(4'd1, 32'h0, "R2 cmd reads 0");

    // R3/R4/R5 single-shot rising on source 3
    wr(4'd0, mkCtrl(3, 1, 0, 0, 0, 0, 0));
    wr(4'd1, 32'h1);
    expectRd(4'd2, 32'h1, "R4 armed");
    srcIn = 32'h0000_0108;
    tick(3);
    expectRd(4'd2, 32'h2, "R4 triggered");
    expectRd(4'd4, 32'h0000_0108, "R5 snapshot");
    peek(4'd3, t1);
    srcIn = 32'h0; tick(2);
    srcIn = 32'h8; tick(3);
    expectRd(4'd3, t1, "R4 ignored after capture");
    expectRd(4'd4, 32'h0000_0108, "R4 snapshot kept");
    srcIn = 32'h0; tick(2);
    wr(4'd1, 32'h1);
    expectRd(4'd2, 32'h1, "R4 rearm clears triggered");
    srcIn = 32'h0000_0208;
    tick(3);
    expectRd(4'd4, 32'h0000_0208, "R4 second capture");

    // R3 falling edge
    srcIn = 32'h0; tick(2);
    wr(4'd0, mkCtrl(3, 2, 0, 0, 0, 0, 0));
    wr(4'd1, 32'h1);
    srcIn = 32'h8; tick(3);
    expectRd(4'd2, 32'h1, "R3 rise ignored in fall mode");
    srcIn = 32'h40; tick(3);
    expectRd(4'd2, 32'h2, "R3 fall captured");
    expectRd(4'd4, 32'h40, "R3 fall snapshot");

    // R3 either edge on source 31
    srcIn = 32'h0; tick(2);
    wr(4'd0, mkCtrl(31, 3, 0, 0, 0, 0, 0));
    wr(4'd1, 32'h1);
    srcIn = 32'h8000_0000; tick(3);
    expectRd(4'd4, 32'h8000_0000, "R3 any-edge rise");
    wr(4'd1, 32'h1);
    srcIn = 32'h0000_0010; tick(3);
    expectRd(4'd2, 32'h2, "R3 any-edge fall");
    expectRd(4'd4, 32'h0000_0010, "R3 any-edge fall snapshot");

    // R3 edge code 0
    srcIn = 32'h0; tick(2);
    wr(4'd0, mkCtrl(31, 0, 0, 0, 0, 0, 0));
    wr(4'd1, 32'h1);
    srcIn = 32'h8000_0000; tick(3);
    srcIn = 32'h0; tick(3);
    expectRd(4'd2, 32'h1, "R3 edge off never fires");

    // R11 disarm
    wr(4'd0, mkCtrl(31, 1, 0, 0, 0, 0, 0));
    wr(4'd1, 32'h2);
    expectRd(4'd2, 32'h0, "R11 disarmed");
    srcIn = 32'h8000_0001; tick(3);
    expectRd(4'd2, 32'h0, "R11 no capture");
    expectRd(4'd4, 32'h0000_0010, "R11 snapshot unchanged");

    // R6 filter length 4 on source 2
    srcIn = 32'h0; tick(3);
    wr(4'd0, mkCtrl(2, 1, 1, 4, 0, 0, 0));
    tick(2);
    wr(4'd1, 32'h1);
    srcIn = 32'h4; tick(2);
    srcIn = 32'h0; tick(4);
    expectRd(4'd2, 32'h1, "R6 short pulse rejected");
    srcIn = 32'h4; tick(3);
    expectRd(4'd2, 32'h1, "R6 not yet accepted at N-1");
    tick(3);
    expectRd(4'd2, 32'h2, "R6 accepted after N clocks");
    srcIn = 32'h0; tick(8);

    // R7 level pre-condition high on source 5, trigger source 1
    wr(4'd0, mkCtrl(1, 1, 0, 0, 5, 1, 0));
    wr(4'd1, 32'h1);
    srcIn = 32'h2; tick(3);
    expectRd(4'd2, 32'h1, "R7 high pre blocks");
    srcIn = 32'h0; tick(2);
    srcIn = 32'h20; tick(2);
    srcIn = 32'h22; tick(3);
    expectRd(4'd2, 32'h2, "R7 high pre passes");
    expectRd(4'd4, 32'h22, "R7 snapshot");
    // low kind
    srcIn = 32'h20; tick(2);
    wr(4'd0, mkCtrl(1, 1, 0, 0, 5, 2, 0));
    wr(4'd1, 32'h1);
    srcIn = 32'h22; tick(3);
    expectRd(4'd2, 32'h1, "R7 low pre blocks");
    srcIn = 32'h0; tick(2);
    srcIn = 32'h2; tick(3);
    expectRd(4'd2, 32'h2, "R7 low pre passes");

    // R8 edge pre-condition in auto-arm style
    srcIn = 32'h0; tick(2);
    wr(4'd0, mkCtrl(1, 1, 0, 0, 5, 3, 1));
    wr(4'd1, 32'h1);
    srcIn = 32'h2; tick(3);
    expectRd(4'd2, 32'h001, "R8 no pre edge yet");
    srcIn = 32'h20; tick(2);
    srcIn = 32'h22; tick(3);
    expectRd(4'd2, 32'h103, "R8 latched pre edge allows");
    srcIn = 32'h20; tick(2);
    srcIn = 32'h22; tick(3);
    expectRd(4'd2, 32'h103, "R8 latch cleared after capture");
    expectRd(4'd6, 32'h22, "R8 buffered snapshot");
    wr(4'd1, 32'h4);
    expectRd(4'd2, 32'h003, "R9 pop empties");

    // R9/R10/R5 auto-arm buffer, either edge on source 0
    srcIn = 32'h0; tick(2);
    wr(4'd0, mkCtrl(0, 3, 0, 0, 0, 0, 1));
    wr(4'd1, 32'h1);
    expectRd(4'd2, 32'h001, "R9 armed empty");
    for (int i = 1; i <= 6; i++) begin
      srcIn = (32'(i) << 8) | 32'(i & 1);
      tick(3);
    end
    expectRd(4'd2, 32'h407, "R10 full with overflow");
    wr(4'd2, 32'h0);
    expectRd(4'd2, 32'h407, "R10 write 0 keeps overflow");
    tPrev = '0;
    for (int j = 1; j <= 4; j++) begin
      expectRd(4'd6, (32'(j) << 8) | 32'(j & 1), "R9 order");
      peek(4'd5, tCur);
      if (j > 1) checkEq(tCur - tPrev, 32'd3, "R5 timestamp spacing");
      tPrev = tCur;
      wr(4'd1, 32'h4);
    end
    expectRd(4'd2, 32'h007, "R10 overflow sticky after drain");
    wr(4'd2, 32'h4);
    expectRd(4'd2, 32'h003, "R10 write 1 clears");

    tick(2);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule